// File: doc/BRIEF.md
# Time-Sliced Shared Memory Arbiter

This block lets one single-port asynchronous SRAM serve two masters: a read-only video fetcher and a host CPU bus that runs on the arbiter clock. Each bus cycle is split into two memory slots. The first slot (A) belongs to the video port and the second slot (B) belongs to the host. Each port's read data is captured at the end of its own slot into a holding register, so each master sees stable data between its fetches. In the default interleaved mode neither master ever waits.

A bus cycle lasts two arbiter clocks (one clock per slot). A divide setting stretches it to four clocks (two clocks per slot), for host buses whose transfer spans four clocks. A mode input selects one of three policies. Interleaving is the default. Host priority lets a host request take the memory in both slots, and the video latch then picks up whatever the memory returns. Video priority permits only one access per bus cycle; a host request that meets a video fetch is stalled with a wait output. Mode and divide are sampled only at bus-cycle boundaries. The host must hold its request stable for a whole bus cycle, and keep holding it while wait is high. The video request and address must be stable for the A slot.

Top module: `arb_shared_mem`

## Requirements
- R1: After reset, vid_data_o and host_rdata_o are zero, host_wait_o is low, the A slot is active (slot_b_o low), interleaved mode is in effect and one clock per slot is used.
- R2: slot_b_o is low for the first half of every bus cycle and high for the second half. Each half lasts one clock when the divide setting is 0 and two clocks when it is 1.
- R3: A video read (vid_rd_i high) places vid_addr_i on the memory during the A slot. The memory data is captured into vid_data_o at the last clock edge of that slot, and vid_data_o changes at no other time.
- R4: A host read (host_rd_i high, host_wr_i low) that is not stalled is served in the B slot. The data is captured into host_rdata_o at the last clock edge of the B slot, and host_rdata_o changes at no other time.
- R5: A host write (host_wr_i high) that is not stalled commits host_wdata_i to host_addr_i with a one-clock mem_we_o pulse on the last clock of the B slot. mem_we_o is never high during an A slot.
- R6: With mode code 1 (host priority) and a host request present, the memory carries host_addr_i in both slots. A video read in that bus cycle then returns the data stored at host_addr_i, as it was before any write in that cycle.
- R7: With mode code 2 (video priority), a host request together with a video read raises host_wait_o for the whole bus cycle. The B slot then makes no memory access, and the held request is served in the next bus cycle that has no video read.
- R8: With mode code 2 and no collision, a video read is served in the A slot and a host request in the B slot, exactly as in interleaved mode.
- R9: mode_i and div_i are sampled only on the clock edge that ends a bus cycle. A change made inside a bus cycle takes effect in the next bus cycle.
- R10: Mode code 0 selects interleaving; reserved code 3 behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Arbiter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Policy: 0 interleave, 1 host priority, 2 video priority, 3 as 0 |
| div_i | input | 1 | 0: one clock per slot, 1: two clocks per slot |
| host_addr_i | input | ADDR_W | Host address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rd_i | input | 1 | Host read request, held for the bus cycle |
| host_wr_i | input | 1 | Host write request, held for the bus cycle |
| host_rdata_o | output | DATA_W | Host read data holding register |
| host_wait_o | output | 1 | Host must hold its request and retry |
| vid_rd_i | input | 1 | Video fetch request |
| vid_addr_i | input | ADDR_W | Video fetch address |
| vid_data_o | output | DATA_W | Video fetch holding register |
| slot_b_o | output | 1 | High while the host (B) slot is active |
| mem_addr_o | output | ADDR_W | SRAM address |
| mem_wdata_o | output | DATA_W | SRAM write data |
| mem_we_o | output | 1 | SRAM write strobe |
| mem_re_o | output | 1 | SRAM output enable |
| mem_rdata_i | input | DATA_W | SRAM read data |

## Verification
A host access and a video fetch can fall in the same bus cycle. What happens then depends on the policy: they share the cycle, the host takes the memory and corrupts the fetch, or the host is stalled. The bench sweeps every policy code and both slot lengths, with every mix of host idle/read/write and video on/off in one bus cycle. For each case it predicts the video latch, the host latch, the wait output and the memory contents from a shadow copy of the memory. A further case changes the mode inside a colliding bus cycle, to show that the policy stays fixed until the boundary.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ARB_ILV      = 2'd0,
    ARB_HOST_PRI = 2'd1,
    ARB_VID_PRI  = 2'd2
  } arb_mode_e;

  function automatic arb_mode_e arb_decode(input logic [1:0] code);
    case (code)
      2'd1:    return ARB_HOST_PRI;
      2'd2:    return ARB_VID_PRI;
      default: return ARB_ILV;
    endcase
  endfunction
endpackage

// File: rtl/arb_slot_timer.sv
module arb_slot_timer
  import arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       div_i,
  output logic       slot_b_o,
  output logic       slot_last_o,
  output arb_mode_e  mode_o
);
  localparam int CNT_W = 2;

  logic [CNT_W-1:0] cnt_q;
  logic             div_q;
  arb_mode_e        mode_q;
  logic             cycle_end;

  assign slot_b_o    = div_q ? cnt_q[1] : cnt_q[0];
  assign slot_last_o = div_q ? cnt_q[0] : 1'b1;
  assign cycle_end   = div_q ? (cnt_q == 2'd3) : (cnt_q == 2'd1);
  assign mode_o      = mode_q;

  // policy and slot length only move on a bus-cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      mode_q <= ARB_ILV;
    end else if (cycle_end) begin
      cnt_q  <= '0;
      div_q  <= div_i;
      mode_q <= arb_decode(mode_i);
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/arb_slot_sel.sv
module arb_slot_sel
  import arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  arb_mode_e          mode_i,
  input  logic               slot_b_i,
  input  logic               slot_last_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  input  logic               host_rd_i,
  input  logic               host_wr_i,
  input  logic               vid_rd_i,
  input  logic [ADDR_W-1:0]  vid_addr_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic               host_wait_o,
  output logic               vid_cap_o,
  output logic               host_cap_o
);
  logic host_req, host_rd_eff, host_take, collide, host_go;

  assign host_req    = host_rd_i | host_wr_i;
  assign host_rd_eff = host_rd_i & ~host_wr_i;
  assign host_take   = (mode_i == ARB_HOST_PRI) & host_req;
  assign collide     = (mode_i == ARB_VID_PRI) & host_req & vid_rd_i;
  assign host_go     = host_req & ~collide;

  assign host_wait_o = collide;
  assign mem_wdata_o = host_wdata_i;

  always_comb begin
    mem_addr_o = vid_addr_i;
    mem_re_o   = 1'b0;
    mem_we_o   = 1'b0;
    vid_cap_o  = 1'b0;
    host_cap_o = 1'b0;
    if (!slot_b_i) begin
      // A slot: video, unless the host has seized the memory
      if (host_take) begin
        mem_addr_o = host_addr_i;
        mem_re_o   = 1'b1;
      end else if (vid_rd_i) begin
        mem_re_o   = 1'b1;
      end
      vid_cap_o = vid_rd_i & slot_last_i;
    end else begin
      mem_addr_o = host_addr_i;
      mem_re_o   = host_go & host_rd_eff;
      mem_we_o   = host_go & host_wr_i & slot_last_i;
      host_cap_o = host_go & host_rd_eff & slot_last_i;
    end
  end
endmodule

// File: rtl/arb_hold_reg.sv
module arb_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/arb_shared_mem.sv
module arb_shared_mem
  import arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              div_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_wait_o,
  input  logic              vid_rd_i,
  input  logic [ADDR_W-1:0] vid_addr_i,
  output logic [DATA_W-1:0] vid_data_o,
  output logic              slot_b_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  arb_mode_e mode_q;
  logic      slot_b, slot_last, vid_cap, host_cap;

  arb_slot_timer u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .div_i       (div_i),
    .slot_b_o    (slot_b),
    .slot_last_o (slot_last),
    .mode_o      (mode_q)
  );

  arb_slot_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
    .mode_i       (mode_q),
    .slot_b_i     (slot_b),
    .slot_last_i  (slot_last),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rd_i    (host_rd_i),
    .host_wr_i    (host_wr_i),
    .vid_rd_i     (vid_rd_i),
    .vid_addr_i   (vid_addr_i),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_we_o     (mem_we_o),
    .mem_re_o     (mem_re_o),
    .host_wait_o  (host_wait_o),
    .vid_cap_o    (vid_cap),
    .host_cap_o   (host_cap)
  );

  arb_hold_reg #(.W(DATA_W)) u_vid_hold (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (vid_cap),
    .d_i (mem_rdata_i), .q_o (vid_data_o)
  );

  arb_hold_reg #(.W(DATA_W)) u_host_hold (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (host_cap),
    .d_i (mem_rdata_i), .q_o (host_rdata_o)
  );

  assign slot_b_o = slot_b;
endmodule

// File: rtl/arb_shared_mem_chk.sv
module arb_shared_mem_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slot_b_o,
  input logic              host_rd_i,
  input logic              host_wr_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              vid_rd_i,
  input logic              host_wait_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] vid_data_o,
  input logic [DATA_W-1:0] host_rdata_o
);
  AST_NO_WRITE_IN_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_b_o |-> !mem_we_o); // R5
  AST_WRITE_AT_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (host_wr_i && mem_addr_o == host_addr_i)); // R5
  AST_VID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vid_data_o) |-> !$past(slot_b_o)); // R3
  AST_HOST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(host_rdata_o) |-> $past(slot_b_o)); // R4
  AST_WAIT_NEEDS_COLLISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wait_o |-> (vid_rd_i && (host_rd_i || host_wr_i))); // R7
  AST_WAIT_B_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wait_o && slot_b_o) |-> !(mem_we_o || mem_re_o)); // R7
endmodule

bind arb_shared_mem arb_shared_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_b_o     (slot_b_o),
  .host_rd_i    (host_rd_i),
  .host_wr_i    (host_wr_i),
  .host_addr_i  (host_addr_i),
  .vid_rd_i     (vid_rd_i),
  .host_wait_o  (host_wait_o),
  .mem_we_o     (mem_we_o),
  .mem_re_o     (mem_re_o),
  .mem_addr_o   (mem_addr_o),
  .vid_data_o   (vid_data_o),
  .host_rdata_o (host_rdata_o)
);

// File: tb/tb_arb_shared_mem.sv
`timescale 1ns/1ps
module tb_arb_shared_mem;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic div_i = 1'b0;
  logic [AW-1:0] host_addr = '0, vid_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_rd = 1'b0, host_wr = 1'b0, vid_rd = 1'b0;
  logic [DW-1:0] host_rdata, vid_data, mem_wdata, mem_rdata;
  logic host_wait, slot_b, mem_we, mem_re;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] exp_vid = '0, exp_host = '0;
  logic [1:0] eff_mode = 2'd0;
  logic eff_div = 1'b0;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  arb_shared_mem #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .div_i(div_i),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rd_i(host_rd),
    .host_wr_i(host_wr), .host_rdata_o(host_rdata), .host_wait_o(host_wait),
    .vid_rd_i(vid_rd), .vid_addr_i(vid_addr), .vid_data_o(vid_data),
    .slot_b_o(slot_b), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata)
  );

  // asynchronous SRAM model
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i * 37 + 5);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle; h: 0 idle, 1 read, 2 write
  task automatic run_cycle(input int h, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                           input bit v, input logic [AW-1:0] va,
                           input bit mid, input logic [1:0] mid_mode);
    bit exp_wait;
    bit hpri, vpri;
    int n, s;
    hpri = (eff_mode == 2'd1);
    vpri = (eff_mode == 2'd2);
    n = eff_div ? 4 : 2;
    s = eff_div ? 2 : 1;
    host_rd = (h == 1); host_wr = (h == 2); host_addr = ha; host_wdata = hd;
    vid_rd = v; vid_addr = va;
    exp_wait = vpri && (h != 0) && v;
    #1;
    check("R7 wait", 32'(host_wait), 32'(exp_wait));
    check("R2 slot A first", 32'(slot_b), 32'd0);
    if (v) exp_vid = (hpri && h != 0) ? shadow[ha] : shadow[va]; // R3 R6
    if (h == 1 && !exp_wait) exp_host = shadow[ha];               // R4 R8
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      #1;
      if (k == 1 && mid) begin
        mode_i = mid_mode;
        #0;
        check("R9 wait unchanged mid cycle", 32'(host_wait), 32'(exp_wait));
      end
      check("R2 slot phase", 32'(slot_b), 32'((k % n) >= s));
    end
    if (h == 2 && !exp_wait) shadow[ha] = hd;                     // R5
    check("R3/R6 video latch", 32'(vid_data), 32'(exp_vid));
    check("R4 host latch", 32'(host_rdata), 32'(exp_host));
    eff_mode = mode_i;
    eff_div  = div_i;
  endtask

  initial begin
    int idx;
    for (int i = 0; i < DEPTH; i++) shadow[i] = DW'(i * 37 + 5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0;
    // R1 reset state
    check("R1 vid_data", 32'(vid_data), 32'd0);
    check("R1 host_rdata", 32'(host_rdata), 32'd0);
    check("R1 wait", 32'(host_wait), 32'd0);
    check("R1 slot", 32'(slot_b), 32'd0);

    idx = 0;
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 4; m++) begin   // m==3 covers R10
        mode_i = 2'(m);
        div_i  = d[0];
        run_cycle(0, '0, '0, 1'b0, '0, 1'b0, '0);
        for (int h = 0; h < 3; h++) begin
          for (int v = 0; v < 2; v++) begin
            idx++;
            run_cycle(h, AW'(idx * 5 + 1), DW'(idx * 29 + 7), v[0], AW'(idx * 3 + 2), 1'b0, '0);
            if (m == 2 && h != 0 && v == 1)  // R7 retry without the video fetch
              run_cycle(h, AW'(idx * 5 + 1), DW'(idx * 29 + 7), 1'b0, AW'(idx * 3 + 2), 1'b0, '0);
          end
        end
      end
    end

    // R9: switch to video priority inside a colliding cycle
    mode_i = 2'd0; div_i = 1'b0;
    run_cycle(0, '0, '0, 1'b0, '0, 1'b0, '0);
    run_cycle(1, 4'd6, '0, 1'b1, 4'd9, 1'b1, 2'd2);
    run_cycle(1, 4'd6, '0, 1'b1, 4'd9, 1'b0, '0);
    run_cycle(1, 4'd6, '0, 1'b0, 4'd9, 1'b0, '0);

    // R5: every committed write is visible through host reads
    mode_i = 2'd0;
    run_cycle(0, '0, '0, 1'b0, '0, 1'b0, '0);
    for (int a = 0; a < DEPTH; a++)
      run_cycle(1, AW'(a), '0, 1'b0, '0, 1'b0, '0);
    for (int a = 0; a < DEPTH; a++)
      check("R5 memory content", 32'(mem[a]), 32'(shadow[a]));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule